// File: doc/BRIEF.md
# Self-Clearing Status Flag Bank

This block holds a small bank of status fields that hardware updates and that software reads with a side effect. Each field is either read-clear, so a read returns it to zero, or read-set, so a read fills it with ones. Typical uses are interrupt-pending or event-capture registers, where hardware raises a flag and software acknowledges it by reading.

Hardware writes one field at a time, or several at once, through a per-field enable and data slice. A single-cycle read strobe shows every field on one read data word in that same cycle. On the next clock edge the read side effect is applied. A hardware write and a read can fall in the same cycle. A per-field precedence bit then decides which one sets the next value. Hardware wins unless software precedence is chosen for that field, so by default no event raised during a read is lost.

Top module: `rdclr_status_bank`

## Requirements
- R1: While `rst` is high at a clock edge, field i loads its reset value, taken from `RST_VALS[i*FIELD_W +: FIELD_W]`.
- R2: When `hw_we[i]` is high and `rd_stb` is low, field i loads `hw_wdata[i*FIELD_W +: FIELD_W]` at the next clock edge.
- R3: Field i is shown on `rd_data[i*FIELD_W +: FIELD_W]`. During a read this is the value held before that read's side effect is applied.
- R4: When `rd_stb` is high and `hw_we[i]` is low, field i becomes all zeros at the next edge if `RD_SET[i]` is 0, or all ones if `RD_SET[i]` is 1.
- R5: When `SW_PREC[i]` is 0 (hardware precedence, the default for every field), a read and a hardware write in the same cycle leave field i holding the written data. The read side effect is dropped for that cycle.
- R6: When `SW_PREC[i]` is 1, a read and a hardware write in the same cycle apply the read side effect. The written data is neither returned by that read nor kept.
- R7: With no read and no hardware write for field i, the field keeps its value.
- R8: Bits of `rd_data` at and above `NUM_FIELDS*FIELD_W` always read 0.
- R9: `rd_data` is valid combinationally in the same cycle as the `rd_stb` pulse. It needs no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_we | input | NUM_FIELDS | Hardware write enable, one bit per field |
| hw_wdata | input | NUM_FIELDS*FIELD_W | Hardware write data, field i in slice i |
| rd_stb | input | 1 | Single-cycle register read strobe |
| rd_data | output | DATA_W | Field values, packed from bit 0, unused bits 0 |

## Verification
A field whose arbitration is wrong shows the error on the very next read of the register. Such a field returns zero or ones when a captured event should still be there, or it keeps a value that should have been lost. The error is visible one cycle after the colliding read. A stuck or mis-slotted field shows on the first read after the disturbing cycle. A reference model follows every field through collisions under both precedence settings and both side-effect kinds. It compares each read word in the cycle of its strobe.

// File: rtl/rdclr_status_bank.sv
module rdclr_status_bank #(
  parameter int                                NUM_FIELDS = 4,
  parameter int                                FIELD_W    = 4,
  parameter int                                DATA_W     = 32,
  parameter logic [NUM_FIELDS-1:0]             RD_SET     = '0,
  parameter logic [NUM_FIELDS-1:0]             SW_PREC    = '0,
  parameter logic [NUM_FIELDS*FIELD_W-1:0]     RST_VALS   = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_FIELDS-1:0]         hw_we,
  input  logic [NUM_FIELDS*FIELD_W-1:0] hw_wdata,
  input  logic                          rd_stb,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int USED_W = NUM_FIELDS * FIELD_W;

  logic [USED_W-1:0] fields_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam logic [FIELD_W-1:0] FILL = RD_SET[i] ? '1 : '0;
    logic take_hw, take_rd;
    assign take_hw = hw_we[i] && !(rd_stb && SW_PREC[i]);
    assign take_rd = rd_stb && !take_hw;

    always_ff @(posedge clk) begin
      if (rst)
        fields_q[i*FIELD_W +: FIELD_W] <= RST_VALS[i*FIELD_W +: FIELD_W];
      else if (take_hw)
        fields_q[i*FIELD_W +: FIELD_W] <= hw_wdata[i*FIELD_W +: FIELD_W];
      else if (take_rd)
        fields_q[i*FIELD_W +: FIELD_W] <= FILL;
    end
  end

  if (DATA_W > USED_W) begin : g_pad
    assign rd_data = {{(DATA_W-USED_W){1'b0}}, fields_q};
  end else begin : g_nopad
    assign rd_data = fields_q[DATA_W-1:0];
  end
endmodule

module rdclr_status_bank_chk #(
  parameter int                            NF   = 4,
  parameter int                            FW   = 4,
  parameter int                            DW   = 32,
  parameter logic [NF-1:0]                 SETM = '0,
  parameter logic [NF-1:0]                 SWM  = '0,
  parameter logic [NF*FW-1:0]              RSTV = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [NF-1:0]    hw_we,
  input logic [NF*FW-1:0] hw_wdata,
  input logic             rd_stb,
  input logic [DW-1:0]    rd_data
);
  for (genvar i = 0; i < NF; i++) begin : g_chk
    localparam logic [FW-1:0] FILL = SETM[i] ? '1 : '0;

    a_r1_reset_value: assert property (@(posedge clk)
      rst |=> rd_data[i*FW +: FW] == RSTV[i*FW +: FW]);

    a_r2_hw_load: assert property (@(posedge clk) disable iff (rst)
      (hw_we[i] && !rd_stb) |=> rd_data[i*FW +: FW] == $past(hw_wdata[i*FW +: FW]));

    a_r4_read_effect: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && !hw_we[i]) |=> rd_data[i*FW +: FW] == FILL);

    if (SWM[i]) begin : g_sw
      a_r6_sw_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && hw_we[i]) |=> rd_data[i*FW +: FW] == FILL);
    end else begin : g_hw
      a_r5_hw_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && hw_we[i]) |=> rd_data[i*FW +: FW] == $past(hw_wdata[i*FW +: FW]));
    end

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (!rd_stb && !hw_we[i]) |=> $stable(rd_data[i*FW +: FW]));
  end
endmodule

bind rdclr_status_bank rdclr_status_bank_chk #(
  .NF(NUM_FIELDS), .FW(FIELD_W), .DW(DATA_W),
  .SETM(RD_SET), .SWM(SW_PREC), .RSTV(RST_VALS)
) u_chk (
  .clk(clk), .rst(rst), .hw_we(hw_we), .hw_wdata(hw_wdata),
  .rd_stb(rd_stb), .rd_data(rd_data)
);

// File: tb/test_rdclr_status_bank.sv
module test_rdclr_status_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int FW = 4;
  localparam int DW = 32;
  localparam logic [NF-1:0]    T_SET = 4'b1100;
  localparam logic [NF-1:0]    T_SW  = 4'b1010;
  localparam logic [NF*FW-1:0] T_RST = 16'h5A03;

  logic clk = 0, rst = 1, rd_stb = 0;
  logic [NF-1:0]    hw_we = '0;
  logic [NF*FW-1:0] hw_wdata = '0;
  logic [DW-1:0]    rd_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [NF*FW-1:0] model;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdclr_status_bank #(.NUM_FIELDS(NF), .FIELD_W(FW), .DATA_W(DW),
    .RD_SET(T_SET), .SW_PREC(T_SW), .RST_VALS(T_RST)) i_rdclr_status_bank (
    .clk(clk), .rst(rst), .hw_we(hw_we), .hw_wdata(hw_wdata),
    .rd_stb(rd_stb), .rd_data(rd_data));

  task automatic step(input logic [NF-1:0] we, input logic [NF*FW-1:0] wd,
                      input logic rd, input string tag);
    hw_we = we; hw_wdata = wd; rd_stb = rd;
    if (rd) begin
      exp_q.push_back({{(DW-NF*FW){1'b0}}, model});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < NF; i++) begin
      if (we[i] && !(rd && T_SW[i])) model[i*FW +: FW] = wd[i*FW +: FW];
      else if (rd) model[i*FW +: FW] = T_SET[i] ? '1 : '0;
    end
    @(posedge clk); #1;
    hw_we = '0; rd_stb = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && rd_stb) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected read: actual %h expected none", rd_data);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    model = T_RST;
    step('0, '0, 1, "R1 reset values, R9 same-cycle data");
    step('0, '0, 1, "R4 read-clear to 0 / read-set to ones");
    step(4'b1111, 16'h1234, 0, "R2");
    step('0, '0, 0, "R7");
    step('0, '0, 1, "R2 hw load, R7 hold");
    step('0, '0, 1, "R8 unused bits zero, R4");
    step(4'b0001, 16'h0001, 1, "R5 collision read shows old value");
    step('0, '0, 1, "R5 hw precedence keeps flag");
    step(4'b0010, 16'h0010, 1, "R6 collision read shows old value");
    step('0, '0, 1, "R6 sw precedence loses flag (read-clear)");
    step(4'b1000, 16'h3000, 1, "R6 collision on read-set field");
    step('0, '0, 1, "R6 sw precedence read-set field all ones");
    step(4'b0100, 16'h0500, 1, "R5 collision on read-set field");
    step('0, '0, 1, "R5 hw precedence read-set field keeps data");
    for (int k = 0; k < 400; k++)
      step(NF'($urandom), (NF*FW)'($urandom), 1'($urandom), "R3 mixed traffic");
    step('0, '0, 1, "R3 final read");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R3 reads missing: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule